// File: doc/BRIEF.md
# Masked Odd-Lane Duplicate Unit

This execution lane takes a vector of 32-bit elements and, for each pair of adjacent elements, writes the value of the upper (odd) element into both output slots of that pair. Elements are copied as raw bit patterns. No floating-point arithmetic takes place, so NaN and denormal encodings come through unchanged and no exception can arise.

A request selects one of three encoding classes. The legacy class works on 128 bits and keeps the old upper destination. The plain-vector class works at 128 or 256 bits and zeroes the destination above that length. The masked class works at 128, 256 or 512 bits with a per-element writemask in merge or zero mode, and it also zeroes the destination above the length. The old destination comes in as an input so that merging and preservation work. A 4-bit reserved register-specifier field must be all ones in both vector classes. A wrong value in that field, an unsupported class, or an unsupported length raises an invalid-opcode flag, and the destination is then returned unchanged. Results are registered and marked by a one-cycle valid pulse.

Top module: `simd_odd_dup`

## Requirements
- R1: For every written pair n, output elements 2n and 2n+1 both equal source element 2n+1. Element k occupies bits [32k+31:32k].
- R2: Legacy class (enc_class=0) with vlen_code=0 (128 bits) writes elements 0..3 and passes old_dst bits 511:128 through unchanged.
- R3: Plain-vector class (enc_class=1) at vlen_code 0 (128) or 1 (256) writes all elements inside the length and zeroes every bit above it.
- R4: In the masked class (enc_class=2) with use_mask=1 and zero_mode=0, an active element whose wmask bit is 0 keeps its old_dst value.
- R5: In the masked class with use_mask=1 and zero_mode=1, an active element whose wmask bit is 0 becomes zero.
- R6: In the masked class with use_mask=0, every active element is written, whatever wmask holds.
- R7: The masked class has 4, 8 or 16 active elements for vlen_code 0, 1 or 2. It zeroes every element above the active count and ignores wmask bits at or above that count.
- R8: In enc_class 1 or 2, a spec_field other than 4'b1111 sets out_ud. The legacy class ignores spec_field.
- R9: out_ud is set for enc_class=3, for vlen_code=3, for a legacy request with vlen_code other than 0, and for a plain-vector request with vlen_code=2.
- R10: When out_ud is set, out_dst equals the old_dst that came with the request.
- R11: Element values, including NaN and denormal patterns, are copied bit for bit.
- R12: A request with in_valid high gives out_valid high on the next cycle only. A synchronous reset clears out_valid, out_ud and out_dst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| enc_class | input | 2 | 0 legacy, 1 plain vector, 2 masked, 3 reserved |
| vlen_code | input | 2 | 0 = 128, 1 = 256, 2 = 512 bits, 3 reserved |
| wmask | input | 16 | Per-element writemask, bit k for element k |
| use_mask | input | 1 | Masked class: 1 applies wmask, 0 writes all elements |
| zero_mode | input | 1 | Masked-off element: 1 zero, 0 merge |
| spec_field | input | 4 | Reserved register-specifier field |
| src | input | 512 | Source vector |
| old_dst | input | 512 | Prior destination value |
| out_valid | output | 1 | Result valid, one-cycle pulse |
| out_ud | output | 1 | Invalid-opcode flag |
| out_dst | output | 512 | New destination value |

## Verification
On every cycle, the assertions check the valid timing and the reset, the invalid-opcode decode for bad classes, lengths and reserved fields, and the pass-through of the old destination on an invalid request. They also check the duplication of the lowest pair, the upper-bit preservation in the legacy class and the upper-bit zeroing in the plain-vector class. Only the bench scenarios can show the per-element merge and zero results under specific masks. The same holds for ignored mask bits above the active count and for NaN and denormal patterns coming through intact, because these need the whole expected vector.

// File: rtl/simd_odd_dup.sv
module simd_odd_dup #(
  parameter int ELEM_W = 32,
  parameter int N_ELEM = 16,
  localparam int DW = ELEM_W * N_ELEM
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        enc_class,
  input  logic [1:0]        vlen_code,
  input  logic [N_ELEM-1:0] wmask,
  input  logic              use_mask,
  input  logic              zero_mode,
  input  logic [3:0]        spec_field,
  input  logic [DW-1:0]     src,
  input  logic [DW-1:0]     old_dst,
  output logic              out_valid,
  output logic              out_ud,
  output logic [DW-1:0]     out_dst
);

  localparam int LEG_N = 128 / ELEM_W;
  localparam int CW    = $clog2(N_ELEM) + 2;

  localparam logic [1:0] C_LEG  = 2'd0;
  localparam logic [1:0] C_VEC  = 2'd1;
  localparam logic [1:0] C_MASK = 2'd2;

  logic          len_bad, spec_bad, ud_c;
  logic [CW-1:0] act_cnt;
  logic [DW-1:0] nxt;

  assign act_cnt  = CW'(LEG_N) << vlen_code;
  assign len_bad  = (vlen_code == 2'd3)
                  | (enc_class == C_LEG && vlen_code != 2'd0)
                  | (enc_class == C_VEC && vlen_code == 2'd2);
  assign spec_bad = (enc_class != C_LEG) && (spec_field != 4'hF);
  assign ud_c     = (enc_class == 2'd3) | len_bad | spec_bad;

  for (genvar j = 0; j < N_ELEM; j++) begin : g_elem
    logic [ELEM_W-1:0] dup, old_e, res;
    logic              active, wr;

    assign dup    = src[(j | 1) * ELEM_W +: ELEM_W];
    assign old_e  = old_dst[j * ELEM_W +: ELEM_W];
    assign active = CW'(j) < act_cnt;
    assign wr     = !use_mask || wmask[j];

    always_comb begin
      if (ud_c)                    res = old_e;
      else if (enc_class == C_LEG) res = (j < LEG_N) ? dup : old_e;
      else if (!active)            res = '0;
      else if (enc_class == C_MASK && !wr) res = zero_mode ? '0 : old_e;
      else                         res = dup;
    end

    assign nxt[j * ELEM_W +: ELEM_W] = res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ud    <= 1'b0;
      out_dst   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ud  <= ud_c;
        out_dst <= nxt;
      end
    end
  end

  p_valid_follows_r12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_single_r12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_reset_clears_r12: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_ud));

  p_bad_class_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (enc_class == 2'd3 || vlen_code == 2'd3)) |=> out_ud);

  p_bad_spec_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc_class != 2'd0 && spec_field != 4'hF) |=> out_ud);

  p_ud_keeps_old_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc_class == 2'd3) |=> (out_dst == $past(old_dst)));

  p_low_pair_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc_class == 2'd1 && vlen_code == 2'd0 && spec_field == 4'hF)
    |=> (out_dst[ELEM_W-1:0] == $past(src[2*ELEM_W-1:ELEM_W]) &&
         out_dst[2*ELEM_W-1:ELEM_W] == $past(src[2*ELEM_W-1:ELEM_W])));

  p_vec_zero_top_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc_class == 2'd1 && vlen_code == 2'd0 && spec_field == 4'hF)
    |=> (out_dst[DW-1:128] == '0));

  p_legacy_keeps_top_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && enc_class == 2'd0 && vlen_code == 2'd0)
    |=> (out_dst[DW-1:128] == $past(old_dst[DW-1:128])));

endmodule

// File: tb/simd_odd_dup_bench.sv
module simd_odd_dup_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int N = 16;
  localparam int DW = W * N;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [1:0] enc_class = '0, vlen_code = '0;
  logic [N-1:0] wmask = '0;
  logic use_mask = 1'b0, zero_mode = 1'b0;
  logic [3:0] spec_field = 4'hF;
  logic [DW-1:0] src = '0, old_dst = '0;
  logic out_valid, out_ud;
  logic [DW-1:0] out_dst;

  int total = 0, bad = 0;
  logic [DW-1:0] q_dst[$];
  logic          q_ud[$];
  string         q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_odd_dup u_simd_odd_dup (
    .clk(clk), .rst(rst), .in_valid(in_valid), .enc_class(enc_class),
    .vlen_code(vlen_code), .wmask(wmask), .use_mask(use_mask),
    .zero_mode(zero_mode), .spec_field(spec_field), .src(src),
    .old_dst(old_dst), .out_valid(out_valid), .out_ud(out_ud),
    .out_dst(out_dst));

  function automatic logic [DW:0] model(input logic [1:0] c, input logic [1:0] v,
      input logic [N-1:0] m, input logic um, input logic zm, input logic [3:0] sp,
      input logic [DW-1:0] s, input logic [DW-1:0] o);
    logic u;
    int kl;
    logic [DW-1:0] d;
    u = 1'b0;
    if (c == 2'd3 || v == 2'd3) u = 1'b1;
    if (c == 2'd0 && v != 2'd0) u = 1'b1;
    if (c == 2'd1 && v == 2'd2) u = 1'b1;
    if ((c == 2'd1 || c == 2'd2) && sp != 4'b1111) u = 1'b1;
    kl = (v == 2'd0) ? 4 : (v == 2'd1) ? 8 : 16;
    d = o;
    if (!u) begin
      for (int k = 0; k < N; k++) begin
        logic [W-1:0] hi;
        hi = s[((k / 2) * 2 + 1) * W +: W];
        if (c == 2'd0) begin
          if (k < 4) d[k*W +: W] = hi;
        end else if (k >= kl) d[k*W +: W] = '0;
        else if (c == 2'd1 || !um || m[k]) d[k*W +: W] = hi;
        else if (zm) d[k*W +: W] = '0;
      end
    end
    return {u, d};
  endfunction

  function automatic logic [DW-1:0] pat(input logic [7:0] seed);
    logic [DW-1:0] r;
    for (int k = 0; k < N; k++) r[k*W +: W] = {seed, 8'(k), 8'h5A, 8'(k * 7 + 3)};
    return r;
  endfunction

  task automatic issue(input string tag, input logic [1:0] c, input logic [1:0] v,
      input logic [N-1:0] m, input logic um, input logic zm, input logic [3:0] sp,
      input logic [DW-1:0] s, input logic [DW-1:0] o);
    logic [DW:0] e;
    @(negedge clk);
    enc_class = c; vlen_code = v; wmask = m; use_mask = um; zero_mode = zm;
    spec_field = sp; src = s; old_dst = o; in_valid = 1'b1;
    e = model(c, v, m, um, zm, sp, s, o);
    q_dst.push_back(e[DW-1:0]);
    q_ud.push_back(e[DW]);
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      total++;
      if (q_dst.size() == 0) begin
        bad++;
        $display("FAIL R12: out_valid act=1 exp=0 (no request pending)");
      end else begin
        logic [DW-1:0] ed;
        logic eu;
        string t;
        ed = q_dst.pop_front();
        eu = q_ud.pop_front();
        t = q_tag.pop_front();
        if (out_dst !== ed || out_ud !== eu) begin
          bad++;
          $display("FAIL %s: ud act=%0b exp=%0b dst act=%h exp=%h", t, out_ud, eu, out_dst, ed);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12: watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] s, o, sn;
    s = pat(8'h11);
    o = pat(8'hC3);
    sn = s;
    sn[1*W +: W] = 32'h7FC0_0001;
    sn[3*W +: W] = 32'h0000_0001;
    sn[15*W +: W] = 32'hFF80_0000;

    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_ud !== 1'b0 || out_dst !== '0) begin
      bad++;
      $display("FAIL R12: reset state act=%0b/%0b exp=0/0", out_valid, out_ud);
    end
    rst = 1'b0;

    issue("R1 R2 legacy", 2'd0, 2'd0, '0, 1'b0, 1'b0, 4'hF, s, o);
    issue("R8 legacy ignores spec", 2'd0, 2'd0, '0, 1'b0, 1'b0, 4'h3, pat(8'h22), o);
    issue("R9 R10 legacy 256", 2'd0, 2'd1, '0, 1'b0, 1'b0, 4'hF, s, o);
    issue("R3 plain 128", 2'd1, 2'd0, 16'hFFFF, 1'b1, 1'b0, 4'hF, s, o);
    issue("R3 R1 plain 256", 2'd1, 2'd1, '0, 1'b0, 1'b1, 4'hF, pat(8'h33), o);
    issue("R9 plain 512", 2'd1, 2'd2, '0, 1'b0, 1'b0, 4'hF, s, o);
    issue("R8 R10 plain bad spec", 2'd1, 2'd0, '0, 1'b0, 1'b0, 4'h7, s, o);
    issue("R6 R11 masked no mask", 2'd2, 2'd2, 16'h0000, 1'b0, 1'b1, 4'hF, sn, o);
    issue("R4 masked merge 512", 2'd2, 2'd2, 16'hA5C3, 1'b1, 1'b0, 4'hF, s, o);
    issue("R5 R7 masked zero 256", 2'd2, 2'd1, 16'hFF0F, 1'b1, 1'b1, 4'hF, s, o);
    issue("R7 R4 masked merge 128", 2'd2, 2'd0, 16'hFFF5, 1'b1, 1'b0, 4'hF, s, o);
    issue("R9 R10 class 3", 2'd3, 2'd0, '0, 1'b0, 1'b0, 4'hF, s, o);
    issue("R9 vlen 3", 2'd2, 2'd3, 16'hFFFF, 1'b1, 1'b0, 4'hF, s, o);
    issue("R8 masked bad spec", 2'd2, 2'd2, 16'hFFFF, 1'b0, 1'b0, 4'hE, s, o);
    idle();

    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R12: out_valid after idle act=%0b exp=0", out_valid);
    end

    issue("R12 single", 2'd2, 2'd1, 16'h0003, 1'b1, 1'b1, 4'hF, pat(8'h44), o);
    idle();
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R12: pulse width act=%0b exp=0", out_valid);
    end

    @(negedge clk);
    total++;
    if (q_dst.size() != 0) begin
      bad++;
      $display("FAIL R12: pending results act=%0d exp=0", q_dst.size());
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule